// File: doc/BRIEF.md
# Line-Doubling Field Scan-out

This block shows one captured video field on a progressive display. A single field holds only every other line of a picture. The block fetches each field line from memory once into a line buffer. It then sends that line out on two consecutive display lines, so the field fills the whole frame height. Per display frame, memory supplies only half a frame of pixels.

Software picks the field to show by writing its start address. The write lands in a shadow register. That value is copied into the working line pointer only when the display controller marks the start of a frame, so a frame in progress never switches fields part-way. Software alternates the address between the two captured fields after each capture completes. If the display refreshes faster than fields arrive and no new address has been written, the same field is simply shown again.

The display controller sends a one-cycle `frame_start` pulse and a one-cycle `line_start` pulse per display line. Memory reads use a valid/ready request channel carrying one pixel address per beat, with addresses in pixel units. Read data returns in request order on a valid-only channel that is always accepted. Pixels leave on a valid/ready stream. While `pix_valid` is high and `pix_ready` is low, `pix_data` and `pix_last` hold still. A pixel transfers on each cycle where both are high. The block never withdraws `pix_valid` before its pixel has transferred.

Top module: `field_double_scan`

## Requirements
- R1: Each field line is sent on exactly two consecutive display lines with identical pixel values. The first frame line, display line 0, and display line 1 both carry field line 0.
- R2: Field line n is read from addresses `base + n*LINE_STRIDE + k` for k = 0 .. LINE_PIX-1, in rising k order. `base` is the start address in effect for the frame.
- R3: One display frame issues exactly FIELD_LINES*LINE_PIX read requests. The second output of a line replays the line buffer and issues no reads.
- R4: A start-address write changes nothing in the frame in progress. The written value takes effect at the next `frame_start`.
- R5: A write in the same cycle as `frame_start` is not used for that frame. It takes effect at the following `frame_start`.
- R6: A frame that begins with no new write since the previous `frame_start` shows the same field again, from the same addresses.
- R7: If a pixel is due for output before its word has been fetched, the pixel is sent as all zeros (black) and `underrun` goes high. `underrun` stays high until reset.
- R8: `pix_data` and `pix_last` hold stable while `pix_valid && !pix_ready`. `pix_last` is 1 exactly on pixel LINE_PIX-1 of each display line.
- R9: A `line_start` is ignored in three cases: while a display line is still being emitted, in a cycle that also carries `frame_start`, and after 2*FIELD_LINES display lines of the current frame.
- R10: While `rd_req_valid && !rd_req_ready`, the request stays valid and `rd_req_addr` holds, except when a new line fetch is being launched.
- R11: After reset, `pix_valid`, `rd_req_valid` and `underrun` are 0, and the shadow start address is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Start-address write strobe |
| cfg_wr_addr | input | AW | Start address to shadow |
| frame_start | input | 1 | Display frame begins (one-cycle pulse) |
| line_start | input | 1 | Display line begins (one-cycle pulse) |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_req_addr | output | AW | Pixel address to read |
| rd_rsp_valid | input | 1 | Read data valid, in request order |
| rd_rsp_data | input | PW | Read data word |
| pix_valid | output | 1 | Output pixel valid |
| pix_ready | input | 1 | Sink accepts the pixel |
| pix_data | output | PW | Output pixel |
| pix_last | output | 1 | Final pixel of the display line |
| underrun | output | 1 | Sticky: a pixel was sent before it was fetched |

## Verification
The bench writes new addresses in the middle of a frame and in the exact cycle of a frame pulse. A design that loads the shadow value too early would show the new field one frame too soon, and the pixel data, which is derived from the address, would mismatch. It counts memory reads per frame, so a design that refetches for the second copy of a line, or skips the doubling, fails the count. It stalls memory across a whole display line to force black pixels and a sticky underrun, then checks that the replayed copy carries the real data. It also sends extra `line_start` pulses during a line and after the last line; a design that restarts or overruns would emit unexpected pixels.

// File: rtl/fds_pkg.sv
package fds_pkg;
  // default geometry shared by the top level and its sub-blocks
  localparam int DEF_AW          = 32;
  localparam int DEF_PW          = 16;
  localparam int DEF_LINE_PIX    = 8;
  localparam int DEF_FIELD_LINES = 4;
  localparam int DEF_LINE_STRIDE = 32;
endpackage

// File: rtl/fds_base_ctrl.sv
module fds_base_ctrl #(
  parameter int AW          = 32,
  parameter int FIELD_LINES = 4,
  parameter int LINE_STRIDE = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          frame_start,
  input  logic          pair_done,
  output logic          fetch_go,
  output logic [AW-1:0] fetch_base
);
  localparam int FW = (FIELD_LINES > 1) ? $clog2(FIELD_LINES) : 1;
  localparam logic [FW-1:0] LAST_FLD = FW'(FIELD_LINES - 1);
  localparam logic [AW-1:0] STEP     = AW'(LINE_STRIDE);

  logic [AW-1:0] shadow_q;
  logic [AW-1:0] line_q;
  logic [FW-1:0] fld_q;
  logic          advance;

  // step to the next field line only after its second display copy
  assign advance    = pair_done && !frame_start && (fld_q != LAST_FLD);
  assign fetch_go   = frame_start || advance;
  assign fetch_base = frame_start ? shadow_q : (line_q + STEP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q <= '0;
      line_q   <= '0;
      fld_q    <= '0;
    end else begin
      if (wr_en) shadow_q <= wr_addr;
      if (frame_start) begin
        line_q <= shadow_q;
        fld_q  <= '0;
      end else if (advance) begin
        line_q <= line_q + STEP;
        fld_q  <= fld_q + 1'b1;
      end
    end
  end

  // R2
  line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> line_q == $past(line_q) + STEP);

  // R4
  base_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_start && !advance) |=> $stable(line_q));
endmodule

// File: rtl/fds_line_fetch.sv
module fds_line_fetch #(
  parameter int AW       = 32,
  parameter int PW       = 16,
  parameter int LINE_PIX = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        go,
  input  logic [AW-1:0]               base,
  output logic                        req_valid,
  input  logic                        req_ready,
  output logic [AW-1:0]               req_addr,
  input  logic                        rsp_valid,
  input  logic [PW-1:0]               rsp_data,
  input  logic [$clog2(LINE_PIX)-1:0] rd_idx,
  output logic [PW-1:0]               rd_data,
  output logic [$clog2(LINE_PIX+1)-1:0] fill_cnt
);
  localparam int IW = $clog2(LINE_PIX);
  localparam int CW = $clog2(LINE_PIX + 1);
  localparam logic [CW-1:0] FULL     = CW'(LINE_PIX);
  localparam logic [CW-1:0] LAST_REQ = CW'(LINE_PIX - 1);

  logic [CW-1:0] req_cnt_q;
  logic [CW-1:0] fill_q;
  logic          busy_q;
  logic [AW-1:0] addr_q;
  logic [PW-1:0] line_mem [LINE_PIX];
  logic          take_rsp;

  assign req_valid = busy_q;
  assign req_addr  = addr_q;
  assign fill_cnt  = fill_q;
  assign rd_data   = line_mem[rd_idx];
  assign take_rsp  = rsp_valid && !go && (fill_q != FULL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      req_cnt_q <= '0;
      addr_q    <= '0;
      fill_q    <= '0;
    end else if (go) begin
      busy_q    <= 1'b1;
      req_cnt_q <= '0;
      addr_q    <= base;
      fill_q    <= '0;
    end else begin
      if (busy_q && req_ready) begin
        addr_q    <= addr_q + 1'b1;
        req_cnt_q <= req_cnt_q + 1'b1;
        if (req_cnt_q == LAST_REQ) busy_q <= 1'b0;
      end
      if (take_rsp) fill_q <= fill_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (take_rsp) line_mem[IW'(fill_q)] <= rsp_data;
  end

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !go) |=> (req_valid && $stable(req_addr)));

  // R3
  req_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_cnt_q < FULL));

  // R3
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= FULL);
endmodule

// File: rtl/fds_pix_out.sv
module fds_pix_out #(
  parameter int PW          = 16,
  parameter int LINE_PIX    = 8,
  parameter int FIELD_LINES = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          frame_start,
  input  logic                          line_start,
  input  logic [$clog2(LINE_PIX+1)-1:0] fill_cnt,
  output logic [$clog2(LINE_PIX)-1:0]   rd_idx,
  input  logic [PW-1:0]                 rd_data,
  output logic                          pix_valid,
  input  logic                          pix_ready,
  output logic [PW-1:0]                 pix_data,
  output logic                          pix_last,
  output logic                          underrun,
  output logic                          pair_done
);
  localparam int IW = $clog2(LINE_PIX);
  localparam int CW = $clog2(LINE_PIX + 1);
  localparam int DL = 2 * FIELD_LINES;
  localparam int DW = $clog2(DL + 1);
  localparam logic [IW-1:0] END_IDX = IW'(LINE_PIX - 1);
  localparam logic [DW-1:0] DL_END  = DW'(DL);

  logic          busy_q;
  logic [IW-1:0] idx_q;
  logic [DW-1:0] dl_q;
  logic          vld_q, last_q, und_q;
  logic [PW-1:0] dat_q;
  logic          load, have, end_px, start;

  assign load      = busy_q && (!vld_q || pix_ready);
  assign have      = CW'(idx_q) < fill_cnt;
  assign end_px    = (idx_q == END_IDX);
  assign start     = line_start && !frame_start && !busy_q && (dl_q != DL_END);
  assign pair_done = load && end_px && dl_q[0];
  assign rd_idx    = idx_q;

  assign pix_valid = vld_q;
  assign pix_data  = dat_q;
  assign pix_last  = last_q;
  assign underrun  = und_q;

  // display-line sequencing
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      dl_q   <= '0;
    end else if (frame_start) begin
      busy_q <= 1'b0;
      dl_q   <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
    end else if (load && end_px) begin
      busy_q <= 1'b0;
      dl_q   <= dl_q + 1'b1;
    end else if (load) begin
      idx_q <= idx_q + 1'b1;
    end
  end

  // output register stage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      last_q <= 1'b0;
      dat_q  <= '0;
      und_q  <= 1'b0;
    end else if (load) begin
      vld_q  <= 1'b1;
      last_q <= end_px;
      dat_q  <= have ? rd_data : '0;
      if (!have) und_q <= 1'b1;
    end else if (pix_ready) begin
      vld_q <= 1'b0;
    end
  end

  // R8
  pix_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_data) && $stable(pix_last)));

  // R7
  und_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> underrun);

  // R7
  und_black_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> (pix_valid && pix_data == '0));

  // R9
  frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dl_q == DL_END && !frame_start && !busy_q) |=> !busy_q);
endmodule

// File: rtl/field_double_scan.sv
module field_double_scan #(
  parameter int AW          = fds_pkg::DEF_AW,
  parameter int PW          = fds_pkg::DEF_PW,
  parameter int LINE_PIX    = fds_pkg::DEF_LINE_PIX,
  parameter int FIELD_LINES = fds_pkg::DEF_FIELD_LINES,
  parameter int LINE_STRIDE = fds_pkg::DEF_LINE_STRIDE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr_en,
  input  logic [AW-1:0] cfg_wr_addr,
  input  logic          frame_start,
  input  logic          line_start,
  output logic          rd_req_valid,
  input  logic          rd_req_ready,
  output logic [AW-1:0] rd_req_addr,
  input  logic          rd_rsp_valid,
  input  logic [PW-1:0] rd_rsp_data,
  output logic          pix_valid,
  input  logic          pix_ready,
  output logic [PW-1:0] pix_data,
  output logic          pix_last,
  output logic          underrun
);
  localparam int IW = $clog2(LINE_PIX);
  localparam int CW = $clog2(LINE_PIX + 1);

  logic          fetch_go;
  logic [AW-1:0] fetch_base;
  logic          pair_done;
  logic [IW-1:0] rd_idx;
  logic [PW-1:0] rd_data;
  logic [CW-1:0] fill_cnt;

  fds_base_ctrl #(
    .AW(AW), .FIELD_LINES(FIELD_LINES), .LINE_STRIDE(LINE_STRIDE)
  ) u_base (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_wr_en), .wr_addr(cfg_wr_addr),
    .frame_start(frame_start), .pair_done(pair_done),
    .fetch_go(fetch_go), .fetch_base(fetch_base)
  );

  fds_line_fetch #(
    .AW(AW), .PW(PW), .LINE_PIX(LINE_PIX)
  ) u_fetch (
    .clk(clk), .rst_n(rst_n),
    .go(fetch_go), .base(fetch_base),
    .req_valid(rd_req_valid), .req_ready(rd_req_ready), .req_addr(rd_req_addr),
    .rsp_valid(rd_rsp_valid), .rsp_data(rd_rsp_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .fill_cnt(fill_cnt)
  );

  fds_pix_out #(
    .PW(PW), .LINE_PIX(LINE_PIX), .FIELD_LINES(FIELD_LINES)
  ) u_out (
    .clk(clk), .rst_n(rst_n),
    .frame_start(frame_start), .line_start(line_start),
    .fill_cnt(fill_cnt), .rd_idx(rd_idx), .rd_data(rd_data),
    .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_data(pix_data), .pix_last(pix_last),
    .underrun(underrun), .pair_done(pair_done)
  );
endmodule

// File: tb/test_field_double_scan.sv
module test_field_double_scan;
  localparam int AW = 32;
  localparam int PW = 16;
  localparam int LP = 8;
  localparam int FL = 4;
  localparam int ST = 32;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          cfg_wr_en = 1'b0;
  logic [AW-1:0] cfg_wr_addr = '0;
  logic          frame_start = 1'b0;
  logic          line_start = 1'b0;
  logic          rd_req_valid;
  logic          rd_req_ready = 1'b0;
  logic [AW-1:0] rd_req_addr;
  logic          rd_rsp_valid = 1'b0;
  logic [PW-1:0] rd_rsp_data = '0;
  logic          pix_valid;
  logic          pix_ready = 1'b0;
  logic [PW-1:0] pix_data;
  logic          pix_last;
  logic          underrun;

  field_double_scan #(
    .AW(AW), .PW(PW), .LINE_PIX(LP), .FIELD_LINES(FL), .LINE_STRIDE(ST)
  ) i_field_double_scan (.*);

  int checks = 0;
  int errors = 0;
  int rd_cnt = 0;
  int pix_cnt = 0;
  int unsigned cyc = 0;
  logic mem_en = 1'b1;

  logic [PW-1:0] exp_q[$];
  logic          exp_last_q[$];
  string         tag_q[$];

  function automatic logic [PW-1:0] mem_word(input logic [AW-1:0] a);
    return a[PW-1:0] ^ PW'(16'h5A3C);
  endfunction

  // memory model and sink pattern
  always @(posedge clk) begin
    cyc          <= cyc + 1;
    rd_req_ready <= mem_en && (cyc % 4 != 3);
    pix_ready    <= (cyc % 5 != 2);
    rd_rsp_valid <= rd_req_valid && rd_req_ready;
    rd_rsp_data  <= mem_word(rd_req_addr);
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_req_valid && rd_req_ready) rd_cnt++;
      if (pix_valid && pix_ready) begin
        pix_cnt++;
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R9 unexpected pixel %h, expected none", pix_data);
        end else begin
          automatic logic [PW-1:0] e = exp_q.pop_front();
          automatic logic          l = exp_last_q.pop_front();
          automatic string         t = tag_q.pop_front();
          if (pix_data !== e || pix_last !== l) begin
            errors++;
            $display("FAIL %s R8 pixel %h last %b, expected %h last %b", t, pix_data, pix_last, e, l);
          end
        end
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired, expected run to end");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string t, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", t, act, exp);
    end
  endtask

  task automatic write_base(input logic [AW-1:0] a);
    @(negedge clk);
    cfg_wr_en = 1'b1;
    cfg_wr_addr = a;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic frame(input logic wr, input logic [AW-1:0] a, output int snap);
    @(negedge clk);
    snap = rd_cnt;
    frame_start = 1'b1;
    cfg_wr_en = wr;
    cfg_wr_addr = a;
    @(negedge clk);
    frame_start = 1'b0;
    cfg_wr_en = 1'b0;
    tick(30);
  endtask

  task automatic do_line(input string t, input logic [AW-1:0] base, input int fl,
                         input logic black, input logic extra);
    for (int k = 0; k < LP; k++) begin
      exp_q.push_back(black ? '0 : mem_word(base + AW'(fl * ST + k)));
      exp_last_q.push_back(k == LP - 1);
      tag_q.push_back(t);
    end
    @(negedge clk);
    line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
    if (extra) begin
      tick(3);
      line_start = 1'b1;
      @(negedge clk);
      line_start = 1'b0;
    end
    while (exp_q.size() != 0) @(negedge clk);
    tick(30);
  endtask

  initial begin
    int snap;
    int pc;
    tick(5);
    rst_n = 1'b1;
    tick(1);
    // R11 reset state
    check("R11 pix_valid", pix_valid, 0);
    check("R11 rd_req_valid", rd_req_valid, 0);
    check("R11 underrun", underrun, 0);

    // R11 shadow start address is zero after reset
    frame(1'b0, '0, snap);
    do_line("R11", 32'h0, 0, 1'b0, 1'b0);

    // full frame from 0x1000, mid-frame write of 0x2000 (R4)
    write_base(32'h1000);
    frame(1'b0, '0, snap);
    for (int dl = 0; dl < 2 * FL; dl++) begin
      if (dl == 3) write_base(32'h2000);
      do_line((dl % 2) ? "R1" : "R2 R4", 32'h1000, dl / 2, 1'b0, dl == 1);
    end
    check("R3 reads per frame", rd_cnt - snap, FL * LP);
    // R9 line_start after the last display line
    pc = pix_cnt;
    @(negedge clk); line_start = 1'b1;
    @(negedge clk); line_start = 1'b0;
    tick(30);
    check("R9 no output past frame end", pix_cnt - pc, 0);

    // R4 the mid-frame write takes effect here
    frame(1'b0, '0, snap);
    for (int dl = 0; dl < 2 * FL; dl++)
      do_line("R4", 32'h2000, dl / 2, 1'b0, 1'b0);
    check("R3 reads per frame second", rd_cnt - snap, FL * LP);

    // R6 no new write: same field again
    frame(1'b0, '0, snap);
    do_line("R6", 32'h2000, 0, 1'b0, 1'b0);
    do_line("R6", 32'h2000, 0, 1'b0, 1'b0);
    do_line("R6", 32'h2000, 1, 1'b0, 1'b0);

    // R5 write in the frame-start cycle
    frame(1'b1, 32'h3000, snap);
    do_line("R5", 32'h2000, 0, 1'b0, 1'b0);
    do_line("R5", 32'h2000, 0, 1'b0, 1'b0);
    frame(1'b0, '0, snap);
    do_line("R5", 32'h3000, 0, 1'b0, 1'b0);
    do_line("R5", 32'h3000, 0, 1'b0, 1'b0);
    check("R7 no underrun yet", underrun, 0);

    // R7 underrun: memory stalled for a whole line
    write_base(32'h4000);
    mem_en = 1'b0;
    frame(1'b0, '0, snap);
    do_line("R7", 32'h4000, 0, 1'b1, 1'b0);
    check("R7 underrun set", underrun, 1);
    mem_en = 1'b1;
    tick(30);
    do_line("R1 replay", 32'h4000, 0, 1'b0, 1'b0);
    do_line("R2", 32'h4000, 1, 1'b0, 1'b0);
    check("R7 underrun sticky", underrun, 1);
    check("R8 queue drained", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule